// File: doc/BRIEF.md
# CPU Clock Ratio Generator

This block produces four related clock-enable pulses for the CPU clock domain. The enables are derived from one of three PLL tick inputs. Each PLL tick input is a one-cycle strobe in the block's single reference-clock domain. A 2-bit selector picks the source. A programmable divider turns the chosen tick stream into the fastest enable. Three fixed post-dividers then derive the slower enables. The ratios of the post-dividers follow a single ratio-mode bit, which selects either the 6:2:1 or the 4:2:1 family.

Software programs the block through a write-only register port with two registers. The control register sits at address 0 and holds the source selector, the divisor and four per-output gates. The mode register sits at address 1 and holds the ratio-mode flag. All outputs are registered pulses in the reference-clock domain and are not derived clocks. A change to the source, the divisor or the ratio mode restarts every divider counter at once, so the four outputs stay phase-aligned. Writing a register with the value it already holds leaves the counters running.

Top module: `cpu_ratio_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, all four enables are low. After reset the selector, divisor, gates and ratio mode are all zero.
- R2: Control bits 5:4 pick the source tick: 0 or 1 selects `pll_core_tick`, 2 selects `pll_mem_tick` and 3 selects `pll_io_tick`. Ticks on the unselected inputs have no effect on any output.
- R3: Control bits 13:8 hold a divisor D, and a value of 0 acts as 1. Output bit 0 (the fastest) pulses on every D-th selected tick, in the cycle after that tick.
- R4: Output bit 1 pulses on every second pulse of the divided rate, in the same cycle as that output-0 pulse.
- R5: Output bit 2 pulses on every second divided pulse when mode-register bit 0 is 0, and on every third when it is 1.
- R6: Output bit 3 pulses on every fourth divided pulse when mode-register bit 0 is 0, and on every sixth when it is 1.
- R7: Control bits 24, 25, 26 and 27 gate outputs 0, 1, 2 and 3; a 1 lets the output pulse. A gated-off output stays low, but its counter keeps running, so re-enabling it keeps its alignment.
- R8: A write that changes the selector, the divisor or the ratio mode clears all counters. No enable pulses in the cycle after that write, and the count restarts from zero. Rewriting an unchanged value does not clear the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_core_tick | input | 1 | Tick strobe from the core PLL |
| pll_mem_tick | input | 1 | Tick strobe from the memory PLL |
| pll_io_tick | input | 1 | Tick strobe from the I/O PLL |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control register, 1 = mode register |
| cfg_wdata | input | 32 | Write data |
| ce_out | output | 4 | Clock-enable pulses; bit 0 fastest, bit 3 slowest |

## Verification
The assertions assume that the tick inputs and the register port are driven with known values from reset onward and change only between clock edges. The bench drives every input on the falling edge and holds each tick as a plain level for one cycle at a time. The assertions also assume that a register write lasts exactly one cycle. The bench's write task raises the strobe for one cycle with no tick during it, while random writes may land on any cycle, including ones that carry ticks.

// File: rtl/cpu_ratio_clkgen.sv
module cpu_ratio_clkgen #(
  parameter int DIV_W   = 6,
  parameter int REG_W   = 32,
  parameter int SEL_LO  = 4,
  parameter int DIV_LO  = 8,
  parameter int GATE_LO = 24,
  parameter int N_OUT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_core_tick,
  input  logic             pll_mem_tick,
  input  logic             pll_io_tick,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [N_OUT-1:0] ce_out
);
  localparam int MID_W  = 2;
  localparam int SLOW_W = 3;

  logic [1:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic [N_OUT-1:0] gate_q;
  logic             mode_q;

  logic [DIV_W-1:0]  div_cnt;
  logic              half_cnt;
  logic [MID_W-1:0]  mid_cnt;
  logic [SLOW_W-1:0] slow_cnt;

  wire ctrl_wr = cfg_wr & ~cfg_addr;
  wire mode_wr = cfg_wr & cfg_addr;
  wire [1:0]       new_sel = cfg_wdata[SEL_LO +: 2];
  wire [DIV_W-1:0] new_div = cfg_wdata[DIV_LO +: DIV_W];
  wire unused_wdata = ^cfg_wdata;

  wire resync = (ctrl_wr & ((new_sel != sel_q) | (new_div != div_q)))
              | (mode_wr & (cfg_wdata[0] != mode_q));

  logic src_tick;
  always_comb begin
    case (sel_q)
      2'd2:    src_tick = pll_mem_tick;
      2'd3:    src_tick = pll_io_tick;
      default: src_tick = pll_core_tick;
    endcase
  end

  wire [DIV_W-1:0]  div_lim  = (div_q == '0) ? '0 : div_q - 1'b1;
  wire [MID_W-1:0]  mid_lim  = mode_q ? MID_W'(2) : MID_W'(1);
  wire [SLOW_W-1:0] slow_lim = mode_q ? SLOW_W'(5) : SLOW_W'(3);

  logic [N_OUT-1:0] raw;
  assign raw[0] = src_tick & (div_cnt == div_lim);
  assign raw[1] = raw[0] & half_cnt;
  assign raw[2] = raw[0] & (mid_cnt == mid_lim);
  assign raw[3] = raw[0] & (slow_cnt == slow_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      div_q  <= '0;
      gate_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        sel_q  <= new_sel;
        div_q  <= new_div;
        gate_q <= cfg_wdata[GATE_LO +: N_OUT];
      end
      if (mode_wr) mode_q <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      half_cnt <= 1'b0;
      mid_cnt  <= '0;
      slow_cnt <= '0;
      ce_out   <= '0;
    end else if (resync) begin
      div_cnt  <= '0;
      half_cnt <= 1'b0;
      mid_cnt  <= '0;
      slow_cnt <= '0;
      ce_out   <= '0;
    end else begin
      if (src_tick) div_cnt <= raw[0] ? '0 : div_cnt + 1'b1;
      if (raw[0]) begin
        half_cnt <= ~half_cnt;
        mid_cnt  <= raw[2] ? '0 : mid_cnt + 1'b1;
        slow_cnt <= raw[3] ? '0 : slow_cnt + 1'b1;
      end
      ce_out <= raw & gate_q;
    end
  end
endmodule

// File: rtl/cpu_ratio_clkgen_chk.sv
module cpu_ratio_clkgen_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_tick,
  input logic [N_OUT-1:0] raw,
  input logic [N_OUT-1:0] gate,
  input logic [N_OUT-1:0] ce,
  input logic             resync,
  input logic             mode,
  input logic [1:0]       mid_cnt,
  input logic [2:0]       slow_cnt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else seen <= 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n && !seen)
      assert_reset_quiet_R1: assert (ce == '0);
  end

  assert_tick_before_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce[0] |-> $past(src_tick));

  assert_half_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] |-> raw[0]) and (raw[3] |-> raw[1]));

  assert_mid_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raw[2] |-> (raw[0] && (mid_cnt == (mode ? 2'd2 : 2'd1))));

  assert_slow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_cnt <= (mode ? 3'd5 : 3'd3));

  assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce & ~$past(gate)) == '0);

  assert_resync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resync) |-> (ce == '0 && mid_cnt == '0 && slow_cnt == '0));
endmodule

bind cpu_ratio_clkgen cpu_ratio_clkgen_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .raw(raw), .gate(gate_q),
  .ce(ce_out), .resync(resync), .mode(mode_q), .mid_cnt(mid_cnt),
  .slow_cnt(slow_cnt)
);

// File: tb/cpu_ratio_clkgen_tb_top.sv
`timescale 1ns/1ps
module cpu_ratio_clkgen_tb_top;
  logic clk = 0, rst_n = 0;
  logic t_core = 0, t_mem = 0, t_io = 0;
  logic wr = 0, addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0] ce;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_ratio_clkgen dut_i (.clk(clk), .rst_n(rst_n), .pll_core_tick(t_core),
    .pll_mem_tick(t_mem), .pll_io_tick(t_io), .cfg_wr(wr), .cfg_addr(addr),
    .cfg_wdata(wdata), .ce_out(ce));

  // behavioural reference
  int m_sel, m_div, m_mode, m_gate, dc, c1, c2, c3;
  logic [3:0] exp_ce = 0;
  always @(posedge clk) begin
    logic tick, rs;
    int d, n2, n3;
    logic [3:0] p;
    if (!rst_n) begin
      m_sel = 0; m_div = 0; m_mode = 0; m_gate = 0;
      dc = 0; c1 = 0; c2 = 0; c3 = 0; exp_ce <= 0;
    end else begin
      rs = wr && ((!addr && (int'(wdata[5:4]) != m_sel || int'(wdata[13:8]) != m_div))
                  || (addr && int'(wdata[0]) != m_mode));
      tick = (m_sel == 2) ? t_mem : (m_sel == 3) ? t_io : t_core;
      p = 0;
      if (rs) begin
        dc = 0; c1 = 0; c2 = 0; c3 = 0;
      end else if (tick) begin
        d = (m_div == 0) ? 1 : m_div;
        n2 = m_mode ? 3 : 2;
        n3 = m_mode ? 6 : 4;
        dc++;
        if (dc == d) begin
          dc = 0;
          p[0] = 1;
          c1 = (c1 + 1) % 2; p[1] = (c1 == 0);
          c2 = (c2 + 1) % n2; p[2] = (c2 == 0);
          c3 = (c3 + 1) % n3; p[3] = (c3 == 0);
        end
      end
      exp_ce <= p & m_gate[3:0];
      if (wr && !addr) begin
        m_sel = wdata[5:4]; m_div = wdata[13:8]; m_gate = wdata[27:24];
      end
      if (wr && addr) m_mode = wdata[0];
    end
  end

  int cnt [4];
  initial for (int k = 0; k < 4; k++) cnt[k] = 0;
  always @(posedge clk) for (int k = 0; k < 4; k++) if (ce[k]) cnt[k]++;

  string tag [4] = '{"R3", "R4", "R5", "R6"};
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        total++;
        if (ce[k] !== exp_ce[k]) begin
          bad++;
          $display("FAIL %s ce[%0d] t=%0t actual=%b expected=%b", tag[k], k, $time, ce[k], exp_ce[k]);
        end
      end
    end
  end

  task automatic chk(string r, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, got, expv);
    end
  endtask

  function automatic logic [31:0] ctrl(int sel, int div, int gates);
    return (32'(gates) << 24) | (32'(div) << 8) | (32'(sel) << 4);
  endfunction

  task automatic wreg(logic a, logic [31:0] d);
    t_core = 0; t_mem = 0; t_io = 0;
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic run(int n, logic [2:0] m);
    for (int i = 0; i < n; i++) begin
      {t_io, t_mem, t_core} = m;
      @(negedge clk);
    end
    t_core = 0; t_mem = 0; t_io = 0;
  endtask

  int base [4];
  task automatic snap();
    for (int k = 0; k < 4; k++) base[k] = cnt[k];
  endtask

  task automatic expect4(string r, int e0, int e1, int e2, int e3);
    run(2, 3'b000);
    chk({r, " out0"}, cnt[0] - base[0], e0);
    chk({r, " out1"}, cnt[1] - base[1], e1);
    chk({r, " out2"}, cnt[2] - base[2], e2);
    chk({r, " out3"}, cnt[3] - base[3], e3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset low", int'(ce), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(ce), 0);
    snap(); run(20, 3'b111);
    expect4("R1 gates zero after reset", 0, 0, 0, 0);

    wreg(0, ctrl(0, 3, 15)); snap(); run(240, 3'b001);
    expect4("R3 R4 R5 R6 div3 mode0", 80, 40, 40, 20);

    wreg(1, 1); wreg(0, ctrl(0, 2, 15)); snap(); run(240, 3'b001);
    expect4("R5 R6 div2 mode1", 120, 60, 40, 20);

    wreg(0, ctrl(0, 0, 15)); snap(); run(24, 3'b001);
    expect4("R3 div0 as 1", 24, 12, 8, 4);

    wreg(1, 0); wreg(0, ctrl(2, 1, 15)); snap(); run(60, 3'b101);
    expect4("R2 sel2 ignores others", 0, 0, 0, 0);
    snap(); run(60, 3'b010);
    expect4("R2 sel2 mem", 60, 30, 30, 15);
    wreg(0, ctrl(3, 2, 15)); snap(); run(40, 3'b011);
    expect4("R2 sel3 ignores others", 0, 0, 0, 0);
    snap(); run(40, 3'b100);
    expect4("R2 sel3 io", 20, 10, 10, 5);
    wreg(0, ctrl(1, 1, 15)); snap(); run(16, 3'b001);
    expect4("R2 sel1 core", 16, 8, 8, 4);

    wreg(0, ctrl(1, 1, 8)); snap(); run(48, 3'b001);
    expect4("R7 only slow gated on", 0, 0, 0, 12);
    wreg(0, ctrl(1, 1, 15)); snap(); run(48, 3'b001);
    expect4("R7 reenable aligned", 48, 24, 24, 12);

    wreg(0, ctrl(0, 5, 15)); run(7, 3'b001);
    wreg(0, ctrl(0, 4, 15)); snap(); run(3, 3'b001);
    expect4("R8 restart after div change", 0, 0, 0, 0);
    snap(); run(1, 3'b001);
    expect4("R8 first pulse after restart", 1, 0, 0, 0);
    run(2, 3'b001);
    wreg(0, ctrl(0, 4, 15)); snap(); run(2, 3'b001);
    expect4("R8 same value keeps count", 1, 1, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      t_core = 1'($urandom); t_mem = 1'($urandom); t_io = 1'($urandom);
      wr = ($urandom % 40) == 0;
      addr = 1'($urandom);
      d = $urandom;
      d[13:8] = 6'($urandom % 6);
      wdata = d;
      @(negedge clk);
    end
    wr = 0; run(4, 3'b000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule